// File: doc/BRIEF.md
# Round-Robin Phase Extraction Array

This block turns a stream of signed complex samples into 8-bit phase codes, one code per sample, for driving a modulator that acts only on phase. Each sample is handled by one identical lane. The lane first scales the real and imaginary magnitudes together so that the larger of the two becomes unity. It then reads the first-octant arctangent from a small table. Finally it folds the result into the right octant and quadrant, using the signs and a swap flag that it recorded before scaling.

A lane takes a long, fixed number of clocks to finish, and it holds only one sample at a time. The array therefore holds as many lanes as one lane's latency. A rotating dispatch pointer hands each valid input to the next lane, and a matching collect pointer reads the lanes in the same rotation. The array accepts a new sample on every clock, with no stalls, and returns results in input order after a constant delay. Both edges of the block are plain valid-qualified streams, with no backpressure.

Top module: `phase_lane_array`

## Requirements
- R1: For a sample (re, im), out_phase equals round(atan2(im, re) * 256 / (2*pi)) taken modulo 256, within one code (circular distance). Code 0 is the positive real axis and codes increase counterclockwise.
- R2: out_valid rises exactly 20 clocks after the clock edge that samples in_valid high. The latency is the same for every sample and for every lane.
- R3: A sample is accepted on every clock that in_valid is high, with no stall. A run of N back-to-back inputs produces N back-to-back outputs, and no more than one lane completes in any cycle.
- R4: Outputs leave in the same order as their inputs entered.
- R5: The input 0 + 0j produces phase code 0.
- R6: Samples that lie on an axis give exact codes: positive real gives 0, positive imaginary gives 64, negative real gives 128 and negative imaginary gives 192.
- R7: Samples with |re| = |im| give exact codes: 32, 96, 160 and 224 for quadrants one to four.
- R8: Full-scale inputs, including the most negative two's-complement value in either component, follow R1. For example, (-32768, -32768) gives 160.
- R9: out_valid is low while rst_n is low, and no output follows inputs that were presented during reset.
- R10: A clock with in_valid low adds no output and does not disturb samples already in flight. A stream with irregular gaps still meets R2 and R4 for every sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample is valid this clock |
| in_re | input | 16 | Real part, signed two's complement |
| in_im | input | 16 | Imaginary part, signed two's complement |
| out_valid | output | 1 | out_phase holds a result this clock |
| out_phase | output | 8 | Phase code, 256 codes per turn, counterclockwise from +real |

## Verification
On every cycle, the bound checker checks several properties. Every output arrives exactly one lane-latency after its input. At most one lane completes per cycle. The number of samples in flight never exceeds the lane count. Whenever nothing is in flight, the dispatch and collect rotations line up. Zero samples and positive-real samples return code 0. The arctangent accuracy, the exact axis and diagonal codes, the full-scale corners and the output ordering for gapped streams are shown only by the bench's scenarios, which compare each result against an independently computed angle.

// File: rtl/phase_array_pkg.sv
// Shared types and the elaboration-time arctangent used to fill the
// first-octant tables. Assumes IEEE real math is available to constant
// functions; nothing here is evaluated at run time.
package phase_array_pkg;

    // Per-sample folding information captured before scaling
    typedef struct packed {
        logic neg_re;   // real part was negative
        logic neg_im;   // imaginary part was negative
        logic swap;     // |im| > |re|, octant result mirrored about 45 degrees
        logic zero;     // both components were zero
    } lane_flags_t;

    // Octant code for table row idx: angle of ratio sampled at the centre of
    // the row, scaled to 2**phase_w codes per turn and rounded
    function automatic int octant_code(input int idx, input int idx_w, input int phase_w);
        real ratio;
        real scale;
        ratio = (real'(idx) + 0.5) / real'(2 ** idx_w);
        scale = real'(2 ** phase_w) / (2.0 * 3.14159265358979);
        return int'($atan(ratio) * scale);
    endfunction

endpackage

// File: rtl/phase_octant_rom.sv
// First-octant arctangent table with a registered read.
// Row i holds the phase code of ratio (i + 0.5) / 2**IDX_W, with the ratio
// taken in [0, 1). Contents are computed at elaboration; no reset is needed
// on the read register because its value is only consumed when the caller
// knows a read has been issued.
module phase_octant_rom
    import phase_array_pkg::*;
#(
    parameter int IDX_W   = 7,
    parameter int PHASE_W = 8
) (
    input  logic                 clk,
    input  logic                 rd_en,
    input  logic [IDX_W-1:0]     idx,
    output logic [PHASE_W-3:0]   code_q
);
    localparam int ROWS  = 2 ** IDX_W;
    localparam int OCT_W = PHASE_W - 2;

    logic [OCT_W-1:0] rom [ROWS];

    for (genvar i = 0; i < ROWS; i++) begin : g_row
        localparam int VAL = octant_code(i, IDX_W, PHASE_W);
        assign rom[i] = OCT_W'(VAL);
    end

    // Table read register
    always_ff @(posedge clk) begin
        if (rd_en) code_q <= rom[idx];
    end

endmodule

// File: rtl/phase_lane.sv
// One phase lane: a single sample in flight, fixed latency LAT clocks.
// Schedule by step count after the capture edge:
//   capture, prepare (abs, swap, signs), NORM_STEPS scaling clocks in which
//   the smaller magnitude is divided by the larger one bit per clock
//   (only the first IDX_W quotient bits are kept), table read, fold/output.
// Assumes a new start arrives no sooner than LAT clocks after the previous.
module phase_lane
    import phase_array_pkg::*;
#(
    parameter int IN_W       = 16,
    parameter int NORM_STEPS = 16,
    parameter int IDX_W      = 7,
    parameter int PHASE_W    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic signed [IN_W-1:0]   re,
    input  logic signed [IN_W-1:0]   im,
    output logic                     done,
    output logic [PHASE_W-1:0]       phase
);
    localparam int LAT     = NORM_STEPS + 4;
    localparam int CNT_W   = $clog2(LAT);
    localparam int OCT_W   = PHASE_W - 2;
    localparam logic [PHASE_W-1:0] QUARTER = PHASE_W'(2 ** (PHASE_W - 2));
    localparam logic [PHASE_W-1:0] HALF    = PHASE_W'(2 ** (PHASE_W - 1));

    logic [CNT_W-1:0]          cnt;
    logic signed [IN_W-1:0]    re_q, im_q;
    logic [IN_W-1:0]           abs_re, abs_im;
    lane_flags_t               flags;
    logic [IN_W-1:0]           big;
    logic [IN_W:0]             rem, dbl, rem_nxt;
    logic                      take;
    logic [IDX_W-1:0]          quo;
    logic [OCT_W-1:0]          oct;
    logic [PHASE_W-1:0]        first_q, mapped;
    logic                      is_prep, is_div, is_read, is_out;

    assign is_prep = (cnt == CNT_W'(1));
    assign is_div  = (cnt >= CNT_W'(2)) && (cnt < CNT_W'(2 + IDX_W));
    assign is_read = (cnt == CNT_W'(LAT - 2));
    assign is_out  = (cnt == CNT_W'(LAT - 1));

    // Step counter: 0 idle, 1..LAT-1 walk the fixed schedule
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (start)          cnt <= CNT_W'(1);
        else if (is_out)         cnt <= '0;
        else if (cnt != '0)      cnt <= cnt + 1'b1;
    end

    // Input capture register
    always_ff @(posedge clk) begin
        if (start) begin
            re_q <= re;
            im_q <= im;
        end
    end

    // Magnitudes of the captured components
    always_comb begin
        abs_re = re_q[IN_W-1] ? IN_W'(-re_q) : IN_W'(re_q);
        abs_im = im_q[IN_W-1] ? IN_W'(-im_q) : IN_W'(im_q);
    end

    // One restoring division step of the smaller magnitude by the larger
    always_comb begin
        dbl     = {rem[IN_W-1:0], 1'b0};
        take    = (dbl >= {1'b0, big});
        rem_nxt = take ? (dbl - {1'b0, big}) : dbl;
    end

    // Prepare and scale: record folding flags, then shift in quotient bits
    always_ff @(posedge clk) begin
        if (is_prep) begin
            flags.neg_re <= re_q[IN_W-1];
            flags.neg_im <= im_q[IN_W-1];
            flags.swap   <= (abs_im > abs_re);
            flags.zero   <= (abs_re == '0) && (abs_im == '0);
            big          <= (abs_im > abs_re) ? abs_im : abs_re;
            rem          <= {1'b0, (abs_im > abs_re) ? abs_re : abs_im};
            quo          <= '0;
        end else if (is_div) begin
            rem <= rem_nxt;
            quo <= {quo[IDX_W-2:0], take};
        end
    end

    phase_octant_rom #(.IDX_W(IDX_W), .PHASE_W(PHASE_W)) u_rom (
        .clk    (clk),
        .rd_en  (is_read),
        .idx    (quo),
        .code_q (oct)
    );

    // Fold the octant code into the full circle
    always_comb begin
        first_q = flags.swap ? (QUARTER - PHASE_W'(oct)) : PHASE_W'(oct);
        unique case ({flags.neg_re, flags.neg_im})
            2'b00:   mapped = first_q;
            2'b10:   mapped = HALF - first_q;
            2'b11:   mapped = HALF + first_q;
            default: mapped = '0 - first_q;
        endcase
        if (flags.zero) mapped = '0;
    end

    // Output register and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done  <= 1'b0;
            phase <= '0;
        end else begin
            done <= is_out;
            if (is_out) phase <= mapped;
        end
    end

endmodule

// File: rtl/phase_lane_array.sv
// Phase extraction array: LANES copies of phase_lane, LANES equal to one
// lane's latency, fed and drained by two rotating pointers so that one
// sample per clock enters and results leave in input order after LANES
// clocks. Assumes no backpressure at the output.
module phase_lane_array
    import phase_array_pkg::*;
#(
    parameter int IN_W       = 16,
    parameter int NORM_STEPS = 16,
    parameter int IDX_W      = 7,
    parameter int PHASE_W    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [IN_W-1:0]   in_re,
    input  logic signed [IN_W-1:0]   in_im,
    output logic                     out_valid,
    output logic [PHASE_W-1:0]       out_phase
);
    localparam int LANES = NORM_STEPS + 4;
    localparam int PTR_W = $clog2(LANES);

    logic [PTR_W-1:0]   disp_ptr, col_ptr;
    logic [LANES-1:0]   lane_done;
    logic [PHASE_W-1:0] lane_phase [LANES];

    // Dispatch rotation: advance on every accepted sample
    always_ff @(posedge clk) begin
        if (!rst_n)        disp_ptr <= '0;
        else if (in_valid) disp_ptr <= (disp_ptr == PTR_W'(LANES - 1)) ? '0 : disp_ptr + 1'b1;
    end

    // Collect rotation: advance on every delivered result
    always_ff @(posedge clk) begin
        if (!rst_n)         col_ptr <= '0;
        else if (out_valid) col_ptr <= (col_ptr == PTR_W'(LANES - 1)) ? '0 : col_ptr + 1'b1;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        phase_lane #(
            .IN_W(IN_W), .NORM_STEPS(NORM_STEPS), .IDX_W(IDX_W), .PHASE_W(PHASE_W)
        ) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .start (in_valid && (disp_ptr == PTR_W'(i))),
            .re    (in_re),
            .im    (in_im),
            .done  (lane_done[i]),
            .phase (lane_phase[i])
        );
    end

    assign out_valid = lane_done[col_ptr];
    assign out_phase = lane_phase[col_ptr];

endmodule

// File: rtl/phase_lane_array_chk.sv
// Checker for phase_lane_array, bound into every instance. Keeps its own
// delay lines of input events so that output timing and special-value codes
// can be related to the inputs that caused them.
module phase_lane_array_chk #(
    parameter int IN_W    = 16,
    parameter int LANES   = 20,
    parameter int PHASE_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic signed [IN_W-1:0]   in_re,
    input logic signed [IN_W-1:0]   in_im,
    input logic                     out_valid,
    input logic [PHASE_W-1:0]       out_phase,
    input logic [LANES-1:0]         lane_done,
    input logic [$clog2(LANES)-1:0] disp_ptr,
    input logic [$clog2(LANES)-1:0] col_ptr
);
    localparam int IF_W = $clog2(LANES + 2) + 1;

    logic [LANES-1:0] hist_v, hist_z, hist_p;
    logic [IF_W-1:0]  inflight;

    // Delay lines: valid, zero sample, positive-real-axis sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_v <= '0;
            hist_z <= '0;
            hist_p <= '0;
        end else begin
            hist_v <= {hist_v[LANES-2:0], in_valid};
            hist_z <= {hist_z[LANES-2:0], in_valid && in_re == '0 && in_im == '0};
            hist_p <= {hist_p[LANES-2:0], in_valid && in_re > 0 && in_im == '0};
        end
    end

    // Samples accepted but not yet delivered
    always_ff @(posedge clk) begin
        if (!rst_n) inflight <= '0;
        else        inflight <= inflight + IF_W'(in_valid) - IF_W'(out_valid);
    end

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == hist_v[LANES-1]);

    assert_one_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lane_done));

    assert_inflight_R3: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= IF_W'(LANES));

    assert_order_ptr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (inflight == '0) |-> (disp_ptr == col_ptr));

    assert_zero_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && hist_z[LANES-1]) |-> (out_phase == '0));

    assert_pos_axis_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && hist_p[LANES-1]) |-> (out_phase == '0));

endmodule

bind phase_lane_array phase_lane_array_chk #(
    .IN_W(IN_W), .LANES(LANES), .PHASE_W(PHASE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_re     (in_re),
    .in_im     (in_im),
    .out_valid (out_valid),
    .out_phase (out_phase),
    .lane_done (lane_done),
    .disp_ptr  (disp_ptr),
    .col_ptr   (col_ptr)
);

// File: tb/sim_phase_lane_array.sv
`timescale 1ns/1ps
module sim_phase_lane_array;
    localparam int IN_W = 16;
    localparam int PHASE_W = 8;
    localparam int LAT = 20;
    localparam real TWO_PI = 2.0 * 3.14159265358979;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [IN_W-1:0] in_re = '0, in_im = '0;
    logic out_valid;
    logic [PHASE_W-1:0] out_phase;

    always #2.5 clk = ~clk;

    phase_lane_array u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_phase(out_phase)
    );

    typedef struct {int code; int tol; int due; string req;} exp_t;
    exp_t sb[$];
    int cyc = 0, checks = 0, fails = 0, outs = 0, sent = 0, run = 0, max_run = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int ref_code(int re, int im);
        int c;
        if (re == 0 && im == 0) return 0;
        c = int'($atan2(real'(im), real'(re)) * 256.0 / TWO_PI);
        return ((c % 256) + 256) % 256;
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Driver: present one valid sample and push its expectation
    task automatic send(int re, int im, int tol, string req);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        in_re = 16'(re);
        in_im = 16'(im);
        e.code = ref_code(re, im); e.tol = tol; e.due = cyc + LAT; e.req = req;
        sb.push_back(e);
        sent++;
    endtask

    // Idle clocks with garbage on the data inputs (R10)
    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_re = 16'($urandom);
            in_im = 16'($urandom);
        end
    endtask

    function automatic int rnd();
        int v;
        v = int'($signed(16'($urandom)));
        return v >>> ($urandom % 16);
    endfunction

    // Monitor: pop and compare every result
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                run++;
                if (run > max_run) max_run = run;
                outs++;
                if (sb.size() == 0) begin
                    check(1'b0, "R10 unexpected output", int'(out_phase), -1);
                end else begin
                    exp_t e;
                    int d;
                    e = sb.pop_front();
                    d = (int'(out_phase) - e.code + 256) % 256;
                    if (d > 128) d = 256 - d;
                    check(d <= e.tol, {e.req, " phase (R1/R4)"}, int'(out_phase), e.code);
                    check(cyc == e.due, "R2 latency", cyc, e.due);
                end
            end else begin
                run = 0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", cyc, 200000);
        report();
        $finish;
    end

    initial begin
        // R9: inputs during reset are ignored
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_re = 16'(100 * k); in_im = 16'(7);
            check(out_valid == 1'b0, "R9 out_valid in reset", int'(out_valid), 0);
        end
        @(negedge clk); rst_n = 1'b1; in_valid = 1'b0;
        for (int k = 0; k < LAT + 5; k++) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R9 no output after reset", int'(out_valid), 0);
        end

        // R5, R6, R7, R8: special values back to back
        send(0, 0, 0, "R5 zero");
        send(1000, 0, 0, "R6 +re");
        send(0, 1000, 0, "R6 +im");
        send(-1000, 0, 0, "R6 -re");
        send(0, -1000, 0, "R6 -im");
        send(5, 5, 0, "R7 q1");
        send(-300, 300, 0, "R7 q2");
        send(-77, -77, 0, "R7 q3");
        send(9000, -9000, 0, "R7 q4");
        send(-32768, -32768, 0, "R8 min,min");
        send(-32768, 0, 0, "R8 min re");
        send(0, -32768, 0, "R8 min im");
        send(-32768, 32767, 1, "R8 min,max");
        send(32767, -32768, 1, "R8 max,min");
        send(1, 0, 0, "R6 tiny +re");
        send(1, 2, 1, "R1 tiny");
        idle(LAT + 5);

        // R1, R3: long gap-free random stream
        for (int k = 0; k < 2000; k++) send(rnd(), rnd(), 1, "R1 burst");
        idle(LAT + 5);
        check(max_run >= 2000, "R3 gap-free run", max_run, 2000);

        // R10, R4: gapped stream
        for (int k = 0; k < 300; k++) begin
            send(rnd(), rnd(), 1, "R10 gapped");
            if ($urandom % 3 == 0) idle(1 + $urandom % 5);
        end
        idle(LAT + 5);

        // R10: long idle produces nothing
        idle(40);
        check(out_valid == 1'b0, "R10 idle output", int'(out_valid), 0);
        check(sb.size() == 0, "R3 all results delivered", sb.size(), 0);
        check(outs == sent, "R3 output count", outs, sent);
        report();
        $finish;
    end
endmodule